// File: doc/BRIEF.md
# Asynchronous Serial Receiver with False-Start Rejection

This block turns an asynchronous serial line into parallel characters for a host. An external receive clock sets the bit rate. The block synchronises that clock into the system clock domain and then divides it by one of three ratios: one, a middle ratio (16 by default) or a high ratio (64 by default). In the two oversampled modes, a falling edge on the line starts a half-bit count. The line is checked again at mid-bit, so a glitch that has already gone away is discarded and the receiver goes back to hunting for a start bit. In the direct mode, each rising edge of the receive clock samples the line once, so the sender must hold the data steady around that edge.

Each data bit is sampled once at its centre, least significant bit first. A character carries 7 or 8 data bits and an optional even or odd parity bit. The receiver then checks the first stop bit. The finished character moves into a holding register together with its parity-error and framing-error flags. This leaves the shift path free for the next frame while the host reads the held character. If a character completes while the holding register is still unread, an overrun flag is raised and the unread character is kept. A carrier-detect input drives a latched carrier-loss flag that clears only under a defined read sequence.

Top module: `serial_rx_top`

## Requirements
- R1: After reset, rx_full, par_err, frm_err, ovr_err and dcd_lost are 0 and rx_data is all zeros.
- R2: The div_sel input selects the bits-per-tick ratio: 0 selects 1, 1 selects DIV_MID and 2 or 3 selects DIV_HIGH. A frame in which every bit lasts that many receive-clock periods is received correctly.
- R3: In the DIV_MID and DIV_HIGH modes, a low pulse on rxd shorter than half a bit raises neither rx_full nor any flag. The next valid frame is received correctly.
- R4: Data bits are taken least significant bit first. With word8=1 there are 8 data bits. With word8=0 there are 7, and bit 7 of rx_data reads 0.
- R5: With par_en=1, one parity bit follows the data. par_odd=0 expects an even count of ones over data and parity, and par_odd=1 expects an odd count. A mismatch sets par_err with the character. With par_en=0, par_err stays 0.
- R6: A low level at the centre of the first stop bit sets frm_err with that character. A high level leaves frm_err clear.
- R7: A completed character sets rx_full and loads rx_data. A one-cycle rd_data pulse clears rx_full, par_err, frm_err and ovr_err. rx_data keeps its value.
- R8: If a character completes while rx_full is 1, ovr_err is set, and rx_data and its error flags keep the unread character.
- R9: A read of the held character while the next frame is being shifted in does not disturb that frame. The frame is delivered intact afterwards.
- R10: dcd high sets dcd_lost. dcd_lost clears only after dcd is low and both an rd_status pulse and an rd_data pulse have been seen while dcd was low. Reads made while dcd is high do not count.
- R11: In the ratio-1 mode, the line is sampled on every receive-clock rising edge, starting with the edge that sees the start bit low. No mid-bit check is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_clk | input | 1 | External receive clock; its rising edges are the sampling ticks |
| rxd | input | 1 | Serial receive line, idle high |
| dcd | input | 1 | Carrier detect; high means carrier lost |
| div_sel | input | 2 | Ratio select: 0 = 1, 1 = DIV_MID, 2/3 = DIV_HIGH |
| word8 | input | 1 | 1 = 8 data bits, 0 = 7 data bits |
| par_en | input | 1 | Parity bit present and checked |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rd_data | input | 1 | One-cycle pulse: host reads the held character |
| rd_status | input | 1 | One-cycle pulse: host reads status |
| rx_data | output | DATA_W | Held character |
| rx_full | output | 1 | Held character not yet read |
| par_err | output | 1 | Parity error of the held character |
| frm_err | output | 1 | Framing error of the held character |
| ovr_err | output | 1 | A character was lost while the held one was unread |
| dcd_lost | output | 1 | Latched carrier loss |

## Verification
The bench builds the block with its default parameters: DIV_MID=16, DIV_HIGH=64, DATA_W=8 and two synchroniser stages. The default ratios let the bench produce glitches that are shorter than half a bit in both oversampled modes. The ratio-1 mode puts the sampling of every bit on a single edge. The 8-bit data width covers both the 7-bit and 8-bit word formats, and the bench checks that the top bit reads 0 in the 7-bit format.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
   typedef enum logic [2:0] {
      ST_HUNT  = 3'd0,
      ST_START = 3'd1,
      ST_DATA  = 3'd2,
      ST_PAR   = 3'd3,
      ST_STOP  = 3'd4
   } rx_state_e;

   typedef struct packed {
      logic word8;
      logic par_en;
      logic par_odd;
   } rx_fmt_t;
endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   input  logic [WIDTH-1:0] rst_val,
   output logic [WIDTH-1:0] d_out
);
   logic [WIDTH-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= rst_val;
               else        chain[s] <= d_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= rst_val;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign d_out = chain[STAGES-1];
endmodule

// File: rtl/serial_rx_frame.sv
module serial_rx_frame
   import serial_rx_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int DIV_MID  = 16,
   parameter int DIV_HIGH = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rxd_s,
   input  logic [1:0]        div_sel,
   input  rx_fmt_t           fmt_in,
   output logic              done,
   output logic [DATA_W-1:0] char_out,
   output logic              char_perr,
   output logic              char_ferr
);
   localparam int CW = $clog2(DIV_HIGH) + 1;
   localparam int BW = $clog2(DATA_W);

   rx_state_e         st;
   logic [CW-1:0]     cnt;
   logic [CW-1:0]     ratio_q;
   logic [CW-1:0]     ratio_sel;
   logic [BW-1:0]     bitn;
   logic [BW-1:0]     last_bit;
   logic [DATA_W-1:0] shreg;
   logic              pbit;
   rx_fmt_t           fmt_q;

   always_comb begin
      case (div_sel)
         2'd0:    ratio_sel = CW'(1);
         2'd1:    ratio_sel = CW'(DIV_MID);
         default: ratio_sel = CW'(DIV_HIGH);
      endcase
   end

   assign last_bit = fmt_q.word8 ? BW'(DATA_W - 1) : BW'(DATA_W - 2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_HUNT;
         cnt       <= '0;
         ratio_q   <= CW'(1);
         bitn      <= '0;
         shreg     <= '0;
         pbit      <= 1'b0;
         fmt_q     <= '0;
         done      <= 1'b0;
         char_out  <= '0;
         char_perr <= 1'b0;
         char_ferr <= 1'b0;
      end else begin
         done <= 1'b0;
         if (tick) begin
            case (st)
               ST_HUNT: begin
                  if (!rxd_s) begin
                     cnt     <= '0;
                     bitn    <= '0;
                     shreg   <= '0;
                     pbit    <= 1'b0;
                     fmt_q   <= fmt_in;
                     ratio_q <= ratio_sel;
                     st      <= (ratio_sel == CW'(1)) ? ST_DATA : ST_START;
                  end
               end
               ST_START: begin
                  if (cnt == (ratio_q >> 1) - CW'(1)) begin
                     cnt <= '0;
                     st  <= rxd_s ? ST_HUNT : ST_DATA;
                  end else begin
                     cnt <= cnt + CW'(1);
                  end
               end
               ST_DATA: begin
                  if (cnt == ratio_q - CW'(1)) begin
                     cnt         <= '0;
                     shreg[bitn] <= rxd_s;
                     if (bitn == last_bit)
                        st <= fmt_q.par_en ? ST_PAR : ST_STOP;
                     else
                        bitn <= bitn + BW'(1);
                  end else begin
                     cnt <= cnt + CW'(1);
                  end
               end
               ST_PAR: begin
                  if (cnt == ratio_q - CW'(1)) begin
                     cnt  <= '0;
                     pbit <= rxd_s;
                     st   <= ST_STOP;
                  end else begin
                     cnt <= cnt + CW'(1);
                  end
               end
               ST_STOP: begin
                  if (cnt == ratio_q - CW'(1)) begin
                     cnt       <= '0;
                     done      <= 1'b1;
                     char_out  <= shreg;
                     char_ferr <= ~rxd_s;
                     char_perr <= fmt_q.par_en & ((^shreg) ^ pbit ^ fmt_q.par_odd);
                     st        <= ST_HUNT;
                  end else begin
                     cnt <= cnt + CW'(1);
                  end
               end
               default: st <= ST_HUNT;
            endcase
         end
      end
   end
endmodule

// File: rtl/serial_rx_hold.sv
module serial_rx_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done,
   input  logic [DATA_W-1:0] char_in,
   input  logic              char_perr,
   input  logic              char_ferr,
   input  logic              rd_data,
   input  logic              rd_status,
   input  logic              dcd_s,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_full,
   output logic              par_err,
   output logic              frm_err,
   output logic              ovr_err,
   output logic              dcd_lost
);
   logic stat_seen;
   logic data_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data <= '0;
         rx_full <= 1'b0;
         par_err <= 1'b0;
         frm_err <= 1'b0;
         ovr_err <= 1'b0;
      end else if (done && rx_full && !rd_data) begin
         ovr_err <= 1'b1;
      end else if (done) begin
         rx_data <= char_in;
         rx_full <= 1'b1;
         par_err <= char_perr;
         frm_err <= char_ferr;
         ovr_err <= 1'b0;
      end else if (rd_data) begin
         rx_full <= 1'b0;
         par_err <= 1'b0;
         frm_err <= 1'b0;
         ovr_err <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dcd_lost  <= 1'b0;
         stat_seen <= 1'b0;
         data_seen <= 1'b0;
      end else if (dcd_s) begin
         dcd_lost  <= 1'b1;
         stat_seen <= 1'b0;
         data_seen <= 1'b0;
      end else if (dcd_lost) begin
         if ((stat_seen || rd_status) && (data_seen || rd_data)) begin
            dcd_lost  <= 1'b0;
            stat_seen <= 1'b0;
            data_seen <= 1'b0;
         end else begin
            stat_seen <= stat_seen | rd_status;
            data_seen <= data_seen | rd_data;
         end
      end
   end
endmodule

// File: rtl/serial_rx_top.sv
module serial_rx_top
   import serial_rx_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int DIV_MID     = 16,
   parameter int DIV_HIGH    = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_clk,
   input  logic              rxd,
   input  logic              dcd,
   input  logic [1:0]        div_sel,
   input  logic              word8,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              rd_data,
   input  logic              rd_status,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_full,
   output logic              par_err,
   output logic              frm_err,
   output logic              ovr_err,
   output logic              dcd_lost
);
   generate
      if (DIV_MID < 2 || (DIV_MID & (DIV_MID - 1)) != 0) begin : g_bad_mid
         $error("DIV_MID must be a power of two of at least 2");
      end
      if (DIV_HIGH < DIV_MID || (DIV_HIGH & (DIV_HIGH - 1)) != 0) begin : g_bad_high
         $error("DIV_HIGH must be a power of two not below DIV_MID");
      end
      if (DATA_W < 2) begin : g_bad_w
         $error("DATA_W must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [2:0]        sync_q;
   logic              rxclk_s, rxd_s, dcd_s;
   logic              rxclk_d;
   logic              tick;
   logic              frm_done;
   logic [DATA_W-1:0] frm_char;
   logic              frm_perr, frm_ferr;
   rx_fmt_t           fmt;

   serial_rx_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_in    ({rx_clk, rxd, dcd}),
      .rst_val (3'b010),
      .d_out   (sync_q)
   );
   assign {rxclk_s, rxd_s, dcd_s} = sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rxclk_d <= 1'b0;
      else        rxclk_d <= rxclk_s;
   end
   assign tick = rxclk_s & ~rxclk_d;

   assign fmt = '{word8: word8, par_en: par_en, par_odd: par_odd};

   serial_rx_frame #(.DATA_W(DATA_W), .DIV_MID(DIV_MID), .DIV_HIGH(DIV_HIGH)) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .rxd_s     (rxd_s),
      .div_sel   (div_sel),
      .fmt_in    (fmt),
      .done      (frm_done),
      .char_out  (frm_char),
      .char_perr (frm_perr),
      .char_ferr (frm_ferr)
   );

   serial_rx_hold #(.DATA_W(DATA_W)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .done      (frm_done),
      .char_in   (frm_char),
      .char_perr (frm_perr),
      .char_ferr (frm_ferr),
      .rd_data   (rd_data),
      .rd_status (rd_status),
      .dcd_s     (dcd_s),
      .rx_data   (rx_data),
      .rx_full   (rx_full),
      .par_err   (par_err),
      .frm_err   (frm_err),
      .ovr_err   (ovr_err),
      .dcd_lost  (dcd_lost)
   );
endmodule

// File: rtl/serial_rx_checker.sv
module serial_rx_checker #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frm_done,
   input logic              rd_data,
   input logic              dcd_s,
   input logic [DATA_W-1:0] rx_data,
   input logic              rx_full,
   input logic              par_err,
   input logic              frm_err,
   input logic              ovr_err,
   input logic              dcd_lost
);
   // R7: a completed character is held
   p_full_on_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      frm_done |=> rx_full);

   // R7: a data read without a new character empties the holding register
   p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data && !frm_done) |=> (!rx_full && !ovr_err && !par_err && !frm_err));

   // R8: a character that arrives while the held one is unread flags overrun and keeps the held one
   p_overrun_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_done && rx_full && !rd_data) |=> (ovr_err && $stable(rx_data)));

   // R9: an unread held character never changes
   p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_full && !rd_data) |=> $stable(rx_data));

   // R5, R6: error flags only accompany a held character
   p_flags_need_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (par_err || frm_err || ovr_err) |-> rx_full);

   // R10: carrier loss latches
   p_dcd_latch_r10: assert property (@(posedge clk) disable iff (!rst_n)
      dcd_s |=> dcd_lost);

   // R10: the flag never clears while carrier detect is high
   p_dcd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (dcd_lost && dcd_s) |=> dcd_lost);
endmodule

bind serial_rx_top serial_rx_checker #(.DATA_W(DATA_W)) u_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .frm_done (frm_done),
   .rd_data  (rd_data),
   .dcd_s    (dcd_s),
   .rx_data  (rx_data),
   .rx_full  (rx_full),
   .par_err  (par_err),
   .frm_err  (frm_err),
   .ovr_err  (ovr_err),
   .dcd_lost (dcd_lost)
);

// File: tb/serial_rx_top_tb.sv
module serial_rx_top_tb;
   localparam int DATA_W = 8;
   localparam int DIV_MID = 16;
   localparam int DIV_HIGH = 64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_clk = 1'b0;
   logic rxd = 1'b1;
   logic dcd = 1'b0;
   logic [1:0] div_sel = 2'd1;
   logic word8 = 1'b1;
   logic par_en = 1'b0;
   logic par_odd = 1'b0;
   logic rd_data = 1'b0;
   logic rd_status = 1'b0;
   logic [DATA_W-1:0] rx_data;
   logic rx_full, par_err, frm_err, ovr_err, dcd_lost;

   int checks = 0;
   int failures = 0;
   bit done_flag = 0;

   always #4 clk = ~clk;

   serial_rx_top #(.DATA_W(DATA_W), .DIV_MID(DIV_MID), .DIV_HIGH(DIV_HIGH)) u_dut (
      .clk(clk), .rst_n(rst_n), .rx_clk(rx_clk), .rxd(rxd), .dcd(dcd),
      .div_sel(div_sel), .word8(word8), .par_en(par_en), .par_odd(par_odd),
      .rd_data(rd_data), .rd_status(rd_status), .rx_data(rx_data),
      .rx_full(rx_full), .par_err(par_err), .frm_err(frm_err),
      .ovr_err(ovr_err), .dcd_lost(dcd_lost)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int ratio_of(input logic [1:0] sel);
      if (sel == 2'd0) return 1;
      if (sel == 2'd1) return DIV_MID;
      return DIV_HIGH;
   endfunction

   function automatic logic [7:0] mask_word(input logic [7:0] d, input logic w8);
      return w8 ? d : {1'b0, d[6:0]};
   endfunction

   function automatic logic good_parity(input logic [7:0] d, input logic odd);
      return (^d) ^ odd;
   endfunction

   task automatic rxtick();
      @(negedge clk) rx_clk = 1'b1;
      repeat (4) @(negedge clk);
      rx_clk = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic send_bit(input logic b);
      rxd = b;
      repeat (ratio_of(div_sel)) rxtick();
   endtask

   task automatic send_frame(input logic [7:0] d, input logic flip_par, input logic stop_bit);
      logic [7:0] m;
      m = mask_word(d, word8);
      send_bit(1'b0);
      for (int i = 0; i < (word8 ? 8 : 7); i++) send_bit(m[i]);
      if (par_en) send_bit(good_parity(m, par_odd) ^ flip_par);
      send_bit(stop_bit);
      rxd = 1'b1;
      repeat (2 * ratio_of(div_sel) + 2) rxtick();
   endtask

   task automatic read_data();
      @(negedge clk) rd_data = 1'b1;
      @(negedge clk) rd_data = 1'b0;
   endtask

   task automatic read_status();
      @(negedge clk) rd_status = 1'b1;
      @(negedge clk) rd_status = 1'b0;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done_flag) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [7:0] d, e;
      process::self().srandom(32'h5EED_0001);
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 rx_full", {31'b0, rx_full}, 0);
      check("R1 flags", {28'b0, par_err, frm_err, ovr_err, dcd_lost}, 0);
      check("R1 rx_data", {24'b0, rx_data}, 0);
      rst_n = 1'b1;
      repeat (4) rxtick();

      // R2, R4: each ratio, 8 bits
      for (int s = 0; s < 3; s++) begin
         div_sel = 2'(s);
         d = 8'hA5 ^ 8'(s * 8'h13);
         send_frame(d, 1'b0, 1'b1);
         check("R2 full", {31'b0, rx_full}, 1);
         check("R2 R4 data", {24'b0, rx_data}, {24'b0, d});
         read_data();
         check("R7 cleared", {31'b0, rx_full}, 0);
      end

      // R4: 7-bit word, top bit reads 0
      div_sel = 2'd1; word8 = 1'b0;
      send_frame(8'hFF, 1'b0, 1'b1);
      check("R4 seven bit", {24'b0, rx_data}, 32'h7F);
      read_data();
      word8 = 1'b1;

      // R3: glitches shorter than half a bit in both oversampled modes
      for (int s = 1; s < 3; s++) begin
         div_sel = 2'(s);
         rxd = 1'b0;
         repeat (ratio_of(div_sel) / 2 - 3) rxtick();
         rxd = 1'b1;
         repeat (2 * ratio_of(div_sel)) rxtick();
         check("R3 no char", {28'b0, rx_full, par_err, frm_err, ovr_err}, 0);
         send_frame(8'h3C, 1'b0, 1'b1);
         check("R3 next frame", {23'b0, rx_full, rx_data}, {23'b0, 1'b1, 8'h3C});
         read_data();
      end

      // R11: ratio 1, a short low pulse is taken as a start bit
      div_sel = 2'd0;
      send_frame(8'h00, 1'b0, 1'b1);
      check("R11 zero char", {23'b0, rx_full, rx_data}, {23'b0, 1'b1, 8'h00});
      read_data();

      // R5: parity error in even and odd modes
      div_sel = 2'd1; par_en = 1'b1;
      for (int o = 0; o < 2; o++) begin
         par_odd = o[0];
         send_frame(8'h6B, 1'b1, 1'b1);
         check("R5 bad parity", {31'b0, par_err}, 1);
         read_data();
         send_frame(8'h6B, 1'b0, 1'b1);
         check("R5 good parity", {31'b0, par_err}, 0);
         read_data();
      end
      par_en = 1'b0;

      // R6: framing error
      send_frame(8'h81, 1'b0, 1'b0);
      check("R6 framing", {30'b0, frm_err, rx_full}, 32'h3);
      check("R6 data", {24'b0, rx_data}, 32'h81);
      read_data();
      check("R7 flags cleared", {29'b0, frm_err, par_err, rx_full}, 0);
      check("R7 data kept", {24'b0, rx_data}, 32'h81);

      // R8: overrun keeps the first character
      send_frame(8'h11, 1'b0, 1'b1);
      send_frame(8'h22, 1'b0, 1'b0);
      check("R8 overrun", {30'b0, ovr_err, rx_full}, 32'h3);
      check("R8 kept", {24'b0, rx_data}, 32'h11);
      check("R8 held flags", {31'b0, frm_err}, 0);
      read_data();
      check("R8 cleared", {31'b0, ovr_err}, 0);

      // R9: a read during the next frame
      send_frame(8'h44, 1'b0, 1'b1);
      fork
         send_frame(8'h99, 1'b0, 1'b1);
         begin
            repeat (5 * DIV_MID * 8) @(negedge clk);
            read_data();
         end
      join
      check("R9 next intact", {22'b0, ovr_err, rx_full, rx_data}, {22'b0, 1'b0, 1'b1, 8'h99});
      read_data();

      // R10: carrier loss
      @(negedge clk) dcd = 1'b1;
      repeat (6) @(negedge clk);
      check("R10 set", {31'b0, dcd_lost}, 1);
      read_status();
      read_data();
      dcd = 1'b0;
      repeat (6) @(negedge clk);
      check("R10 reads while high ignored", {31'b0, dcd_lost}, 1);
      read_status();
      repeat (3) @(negedge clk);
      check("R10 status alone", {31'b0, dcd_lost}, 1);
      read_data();
      repeat (3) @(negedge clk);
      check("R10 cleared", {31'b0, dcd_lost}, 0);

      // R2, R4, R5, R6: random frames
      for (int n = 0; n < 20; n++) begin
         logic fp, sb;
         div_sel = ($urandom % 4 == 0) ? 2'd2 : 2'($urandom % 2);
         word8   = 1'($urandom);
         par_en  = 1'($urandom);
         par_odd = 1'($urandom);
         d  = 8'($urandom);
         fp = ($urandom % 4 == 0);
         sb = ($urandom % 5 != 0);
         e  = mask_word(d, word8);
         send_frame(d, fp, sb);
         check("R2 R4 random data", {24'b0, rx_data}, {24'b0, e});
         check("R5 R6 random flags", {29'b0, rx_full, par_err, frm_err},
               {29'b0, 1'b1, par_en & fp, ~sb});
         read_data();
      end

      done_flag = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule